// File: doc/BRIEF.md
# Ethernet Preamble Insert and Recover

This block sits on the byte-wide datapath of an Ethernet MAC and handles the preamble in both directions. On transmit it sees the first byte of a frame arrive and holds it. It then emits a preamble of programmable length and the start-of-frame delimiter, and only after that lets the frame bytes through. The preamble is normally the standard 0x55 pattern. If user preambles are enabled and one has been loaded, that preamble is sent in its place, and it serves exactly one frame.

On receive the block hunts for the delimiter byte 0xD5 and removes everything before it. When preamble recovery is enabled, the stripped preamble is returned as a 56-bit sideband word. The word is zero-padded at the top when the preamble was short and keeps only the most recent seven bytes when it was long. A one-cycle strobe marks the word, and it comes before the first frame byte is offered downstream.

Configuration is read once per frame: at the first transmit byte for the transmit side, and at the delimiter for the receive side. Changes made while a frame is in flight apply to the next frame.

Top module: `eth_preamble_unit`

## Requirements
- R1: A transmitted frame starts with N bytes of 0x55, then one byte 0xD5, then the frame bytes unchanged, where N is the effective preamble length.
- R2: The effective length is `cfg_pre_len_i` (bytes) when it lies in 3..15. A programmed value of 0, 1 or 2 gives 3.
- R3: With `cfg_tx_user_en_i` set and a user preamble loaded, the N preamble bytes come from the loaded value: byte i is `upre_bytes_i[8*i+7:8*i]`, and byte 0 is sent first. The load is consumed by that frame. A frame started with the enable cleared leaves the load in place.
- R4: With `cfg_tx_user_en_i` set and no user preamble loaded, the standard 0x55 preamble is sent.
- R5: `tx_in_ready_o` stays low until the delimiter has been accepted downstream. After that, each accepted input byte appears on the output in the same cycle, and `tx_out_last_o` marks the last byte.
- R6: Length and user-enable are sampled when a frame starts. A change during the frame has no effect on that frame.
- R7: On receive, the bytes up to and including the first 0xD5 are removed. The bytes after it, through the byte marked by `rx_in_last_i`, are delivered unchanged with last on the final one.
- R8: With `cfg_rx_keep_en_i` set at the delimiter, `rx_pre_valid_o` pulses for one cycle in which `rx_out_valid_o` is low. The pulse comes before the first frame byte is offered. `rx_pre_word_o` then holds the last seven preamble bytes, with the most recent in bits [7:0].
- R9: A recovered preamble shorter than seven bytes is padded with zero bytes in the upper positions of the word.
- R10: With `cfg_rx_keep_en_i` clear at the delimiter, `rx_pre_valid_o` stays low for the frame.
- R11: While an output is valid and its ready is low, valid stays high and the data stays stable.
- R12: During and right after reset, `tx_out_valid_o`, `tx_in_ready_o`, `rx_out_valid_o` and `rx_pre_valid_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_pre_len_i | input | 4 | Transmit preamble length in bytes |
| cfg_tx_user_en_i | input | 1 | Send the loaded user preamble instead of the standard one |
| cfg_rx_keep_en_i | input | 1 | Recover the received preamble as a sideband word |
| upre_load_i | input | 1 | Load strobe for the user preamble |
| upre_bytes_i | input | 120 | User preamble bytes, byte 0 in the lowest bits |
| tx_in_data_i | input | 8 | Transmit frame byte from the MAC |
| tx_in_valid_i | input | 1 | Transmit input valid |
| tx_in_last_i | input | 1 | Last byte of the transmit frame |
| tx_in_ready_o | output | 1 | Transmit input ready |
| tx_out_data_o | output | 8 | Byte toward the line |
| tx_out_valid_o | output | 1 | Transmit output valid |
| tx_out_last_o | output | 1 | Last byte of the transmit frame |
| tx_out_ready_i | input | 1 | Transmit output ready |
| rx_in_data_i | input | 8 | Byte from the line |
| rx_in_valid_i | input | 1 | Receive input valid |
| rx_in_last_i | input | 1 | Last byte of the received frame |
| rx_in_ready_o | output | 1 | Receive input ready |
| rx_out_data_o | output | 8 | Received frame byte |
| rx_out_valid_o | output | 1 | Receive output valid |
| rx_out_last_o | output | 1 | Last byte of the received frame |
| rx_out_ready_i | input | 1 | Receive output ready |
| rx_pre_word_o | output | 56 | Recovered preamble, most recent byte in [7:0] |
| rx_pre_valid_o | output | 1 | One-cycle strobe for the recovered preamble |

## Verification
Transmit frames are tried with the standard pattern at the nominal length, at both clamp edges, and at an in-range length. The bench also sends a user preamble that is loaded, one that is not loaded, and one that is loaded while the enable is off. Together these separate a wrong byte count from a wrong byte source and from a load that is consumed at the wrong time. A configuration change landing mid-preamble shows whether the block samples once per frame. Receive frames use preambles of zero, three, seven and twelve bytes with recovery on and off, which separates zero padding, truncation to the newest bytes and suppression of the strobe. Random frames with random downstream stalls and input bubbles then exercise hold-under-backpressure on both paths.

// File: rtl/eth_pre_pkg.sv
package eth_pre_pkg;
  localparam logic [7:0] STD_BYTE = 8'h55;
  localparam logic [7:0] SFD_BYTE = 8'hD5;

  typedef enum logic [1:0] {TX_IDLE, TX_PRE, TX_SFD, TX_DATA} tx_state_e;
  typedef enum logic [1:0] {RX_HUNT, RX_EMIT, RX_DATA} rx_state_e;
endpackage

// File: rtl/pre_user_buf.sv
module pre_user_buf #(
  parameter int UPRE_W = 120
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [UPRE_W-1:0] data_i,
  input  logic              take_i,
  output logic [UPRE_W-1:0] data_o,
  output logic              loaded_o
);
  logic [UPRE_W-1:0] data_q;
  logic              loaded_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q   <= '0;
      loaded_q <= 1'b0;
    end else begin
      if (load_i) data_q <= data_i;
      // a fresh load wins over a same-cycle take
      if (load_i)      loaded_q <= 1'b1;
      else if (take_i) loaded_q <= 1'b0;
    end
  end

  assign data_o   = data_q;
  assign loaded_o = loaded_q;

  assert_load_sets_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> loaded_o);
endmodule

// File: rtl/pre_tx_insert.sv
module pre_tx_insert
  import eth_pre_pkg::*;
#(
  parameter int MAX_PRE_BYTES = 15,
  parameter int MIN_PRE_BYTES = 3,
  localparam int LEN_W  = $clog2(MAX_PRE_BYTES + 1),
  localparam int UPRE_W = MAX_PRE_BYTES * 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LEN_W-1:0]  cfg_len_i,
  input  logic              cfg_user_en_i,
  input  logic [UPRE_W-1:0] upre_i,
  input  logic              upre_loaded_i,
  output logic              upre_take_o,
  input  logic [7:0]        in_data_i,
  input  logic              in_valid_i,
  input  logic              in_last_i,
  output logic              in_ready_o,
  output logic [7:0]        out_data_o,
  output logic              out_valid_o,
  output logic              out_last_o,
  input  logic              out_ready_i
);
  localparam logic [LEN_W-1:0] LEN_MIN = LEN_W'(MIN_PRE_BYTES);
  localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(MAX_PRE_BYTES);

  tx_state_e         state_q;
  logic [LEN_W-1:0]  left_q;
  logic [UPRE_W-1:0] pre_sr_q;
  logic [LEN_W-1:0]  eff_len;
  logic              start;
  logic              fire;

  always_comb begin
    if (cfg_len_i < LEN_MIN)      eff_len = LEN_MIN;
    else if (cfg_len_i > LEN_MAX) eff_len = LEN_MAX;
    else                          eff_len = cfg_len_i;
  end

  assign start       = (state_q == TX_IDLE) && in_valid_i;
  assign upre_take_o = start && cfg_user_en_i;

  always_comb begin
    out_valid_o = 1'b0;
    out_data_o  = '0;
    out_last_o  = 1'b0;
    in_ready_o  = 1'b0;
    unique case (state_q)
      TX_PRE: begin
        out_valid_o = 1'b1;
        out_data_o  = pre_sr_q[7:0];
      end
      TX_SFD: begin
        out_valid_o = 1'b1;
        out_data_o  = SFD_BYTE;
      end
      TX_DATA: begin
        out_valid_o = in_valid_i;
        out_data_o  = in_data_i;
        out_last_o  = in_last_i;
        in_ready_o  = out_ready_i;
      end
      default: ;
    endcase
  end

  assign fire = out_valid_o && out_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= TX_IDLE;
      left_q   <= '0;
      pre_sr_q <= '0;
    end else begin
      unique case (state_q)
        TX_IDLE: if (start) begin
          state_q  <= TX_PRE;
          left_q   <= eff_len;
          pre_sr_q <= (cfg_user_en_i && upre_loaded_i) ? upre_i
                                                       : {MAX_PRE_BYTES{STD_BYTE}};
        end
        TX_PRE: if (fire) begin
          left_q   <= left_q - LEN_W'(1);
          pre_sr_q <= pre_sr_q >> 8;
          if (left_q == LEN_W'(1)) state_q <= TX_SFD;
        end
        TX_SFD:  if (fire) state_q <= TX_DATA;
        TX_DATA: if (fire && in_last_i) state_q <= TX_IDLE;
        default: state_q <= TX_IDLE;
      endcase
    end
  end

  assert_no_early_data_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ready_o |-> ($past(state_q) == TX_SFD || $past(state_q) == TX_DATA));

  assert_tx_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o)));

  assert_pre_len_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == TX_PRE) |-> (left_q != '0 && left_q <= LEN_MAX));
endmodule

// File: rtl/pre_rx_recover.sv
module pre_rx_recover
  import eth_pre_pkg::*;
#(
  parameter int KEEP_BYTES = 7,
  localparam int KEEP_W = KEEP_BYTES * 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_keep_en_i,
  input  logic [7:0]        in_data_i,
  input  logic              in_valid_i,
  input  logic              in_last_i,
  output logic              in_ready_o,
  output logic [7:0]        out_data_o,
  output logic              out_valid_o,
  output logic              out_last_o,
  input  logic              out_ready_i,
  output logic [KEEP_W-1:0] pre_word_o,
  output logic              pre_valid_o
);
  rx_state_e         state_q;
  logic [KEEP_W-1:0] pre_sr_q;
  logic              keep_q;
  logic              is_sfd;

  assign is_sfd      = in_data_i == SFD_BYTE;
  assign in_ready_o  = (state_q == RX_HUNT) || ((state_q == RX_DATA) && out_ready_i);
  assign out_valid_o = (state_q == RX_DATA) && in_valid_i;
  assign out_data_o  = in_data_i;
  assign out_last_o  = (state_q == RX_DATA) && in_last_i;
  assign pre_word_o  = pre_sr_q;
  assign pre_valid_o = (state_q == RX_EMIT) && keep_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= RX_HUNT;
      pre_sr_q <= '0;
      keep_q   <= 1'b0;
    end else begin
      unique case (state_q)
        RX_HUNT: if (in_valid_i) begin
          if (is_sfd) begin
            state_q <= RX_EMIT;
            keep_q  <= cfg_keep_en_i;
          end else begin
            // zeros shift up from the bottom: short preambles come out padded
            pre_sr_q <= {pre_sr_q[KEEP_W-9:0], in_data_i};
          end
        end
        RX_EMIT: state_q <= RX_DATA;
        RX_DATA: if (in_valid_i && out_ready_i && in_last_i) begin
          state_q  <= RX_HUNT;
          pre_sr_q <= '0;
        end
        default: state_q <= RX_HUNT;
      endcase
    end
  end

  assert_strobe_after_sfd_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_valid_o |-> $past(in_valid_i && in_ready_o && in_data_i == SFD_BYTE));

  assert_strobe_no_data_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_valid_o |-> !out_valid_o);

  assert_strobe_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_valid_o |=> !pre_valid_o);

  assert_rx_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o)));
endmodule

// File: rtl/eth_preamble_unit.sv
module eth_preamble_unit #(
  parameter int MAX_PRE_BYTES = 15,
  parameter int MIN_PRE_BYTES = 3,
  parameter int RX_KEEP_BYTES = 7,
  localparam int LEN_W  = $clog2(MAX_PRE_BYTES + 1),
  localparam int UPRE_W = MAX_PRE_BYTES * 8,
  localparam int KEEP_W = RX_KEEP_BYTES * 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LEN_W-1:0]  cfg_pre_len_i,
  input  logic              cfg_tx_user_en_i,
  input  logic              cfg_rx_keep_en_i,
  input  logic              upre_load_i,
  input  logic [UPRE_W-1:0] upre_bytes_i,
  input  logic [7:0]        tx_in_data_i,
  input  logic              tx_in_valid_i,
  input  logic              tx_in_last_i,
  output logic              tx_in_ready_o,
  output logic [7:0]        tx_out_data_o,
  output logic              tx_out_valid_o,
  output logic              tx_out_last_o,
  input  logic              tx_out_ready_i,
  input  logic [7:0]        rx_in_data_i,
  input  logic              rx_in_valid_i,
  input  logic              rx_in_last_i,
  output logic              rx_in_ready_o,
  output logic [7:0]        rx_out_data_o,
  output logic              rx_out_valid_o,
  output logic              rx_out_last_o,
  input  logic              rx_out_ready_i,
  output logic [KEEP_W-1:0] rx_pre_word_o,
  output logic              rx_pre_valid_o
);
  logic [UPRE_W-1:0] upre_q;
  logic              upre_loaded;
  logic              upre_take;

  pre_user_buf #(.UPRE_W(UPRE_W)) u_user (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (upre_load_i),
    .data_i   (upre_bytes_i),
    .take_i   (upre_take),
    .data_o   (upre_q),
    .loaded_o (upre_loaded)
  );

  pre_tx_insert #(
    .MAX_PRE_BYTES (MAX_PRE_BYTES),
    .MIN_PRE_BYTES (MIN_PRE_BYTES)
  ) u_tx (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .cfg_len_i     (cfg_pre_len_i),
    .cfg_user_en_i (cfg_tx_user_en_i),
    .upre_i        (upre_q),
    .upre_loaded_i (upre_loaded),
    .upre_take_o   (upre_take),
    .in_data_i     (tx_in_data_i),
    .in_valid_i    (tx_in_valid_i),
    .in_last_i     (tx_in_last_i),
    .in_ready_o    (tx_in_ready_o),
    .out_data_o    (tx_out_data_o),
    .out_valid_o   (tx_out_valid_o),
    .out_last_o    (tx_out_last_o),
    .out_ready_i   (tx_out_ready_i)
  );

  pre_rx_recover #(.KEEP_BYTES(RX_KEEP_BYTES)) u_rx (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .cfg_keep_en_i (cfg_rx_keep_en_i),
    .in_data_i     (rx_in_data_i),
    .in_valid_i    (rx_in_valid_i),
    .in_last_i     (rx_in_last_i),
    .in_ready_o    (rx_in_ready_o),
    .out_data_o    (rx_out_data_o),
    .out_valid_o   (rx_out_valid_o),
    .out_last_o    (rx_out_last_o),
    .out_ready_i   (rx_out_ready_i),
    .pre_word_o    (rx_pre_word_o),
    .pre_valid_o   (rx_pre_valid_o)
  );

  assert_reset_quiet_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (!tx_out_valid_o && !rx_pre_valid_o));
endmodule

// File: tb/tb_eth_preamble_unit.sv
`timescale 1ns/1ps
module tb_eth_preamble_unit;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [3:0]   cfg_len = 4'd7;
  logic         cfg_tx_user = 1'b0;
  logic         cfg_rx_keep = 1'b0;
  logic         upre_load = 1'b0;
  logic [119:0] upre_bytes = '0;
  logic [7:0]   tx_in_data = '0;
  logic         tx_in_valid = 1'b0;
  logic         tx_in_last = 1'b0;
  logic         tx_in_ready;
  logic [7:0]   tx_out_data;
  logic         tx_out_valid;
  logic         tx_out_last;
  logic         tx_out_ready = 1'b1;
  logic [7:0]   rx_in_data = '0;
  logic         rx_in_valid = 1'b0;
  logic         rx_in_last = 1'b0;
  logic         rx_in_ready;
  logic [7:0]   rx_out_data;
  logic         rx_out_valid;
  logic         rx_out_last;
  logic         rx_out_ready = 1'b1;
  logic [55:0]  rx_pre_word;
  logic         rx_pre_valid;

  always #10 clk = ~clk;

  eth_preamble_unit dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_pre_len_i(cfg_len), .cfg_tx_user_en_i(cfg_tx_user), .cfg_rx_keep_en_i(cfg_rx_keep),
    .upre_load_i(upre_load), .upre_bytes_i(upre_bytes),
    .tx_in_data_i(tx_in_data), .tx_in_valid_i(tx_in_valid), .tx_in_last_i(tx_in_last),
    .tx_in_ready_o(tx_in_ready),
    .tx_out_data_o(tx_out_data), .tx_out_valid_o(tx_out_valid), .tx_out_last_o(tx_out_last),
    .tx_out_ready_i(tx_out_ready),
    .rx_in_data_i(rx_in_data), .rx_in_valid_i(rx_in_valid), .rx_in_last_i(rx_in_last),
    .rx_in_ready_o(rx_in_ready),
    .rx_out_data_o(rx_out_data), .rx_out_valid_o(rx_out_valid), .rx_out_last_o(rx_out_last),
    .rx_out_ready_i(rx_out_ready),
    .rx_pre_word_o(rx_pre_word), .rx_pre_valid_o(rx_pre_valid)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;
  bit bp = 0;
  int cyc = 0;

  bit           tb_loaded = 0;
  logic [119:0] tb_upre = '0;

  logic [8:0]   txq[$];
  logic [8:0]   rxq[$];
  int           strobes;
  logic [55:0]  strobe_word;
  int           strobe_cyc;
  int           first_cyc;

  logic         txv_p = 0, txr_p = 0, rxv_p = 0, rxr_p = 0;
  logic [7:0]   txd_p = 0, rxd_p = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    tx_out_ready <= bp ? ($urandom % 4 != 0) : 1'b1;
    rx_out_ready <= bp ? ($urandom % 4 != 0) : 1'b1;
  end

  // monitors (read pre-update values at the edge)
  always @(posedge clk) begin
    cyc++;
    if (rst_n) begin
      if (txv_p && !txr_p)
        chk(tx_out_valid && tx_out_data == txd_p, "R11", "tx hold", tx_out_data, txd_p);
      if (rxv_p && !rxr_p)
        chk(rx_out_valid && rx_out_data == rxd_p, "R11", "rx hold", rx_out_data, rxd_p);
      if (tx_in_valid && tx_in_ready)
        chk(tx_out_valid && tx_out_ready && tx_out_data == tx_in_data, "R5", "passthrough",
            tx_out_data, tx_in_data);
      if (tx_out_valid && tx_out_ready) txq.push_back({tx_out_last, tx_out_data});
      if (rx_pre_valid) begin
        strobes++;
        strobe_word = rx_pre_word;
        strobe_cyc  = cyc;
      end
      if (rx_out_valid && rx_out_ready) begin
        if (rxq.size() == 0) first_cyc = cyc;
        rxq.push_back({rx_out_last, rx_out_data});
      end
    end
    txv_p = tx_out_valid; txr_p = tx_out_ready; txd_p = tx_out_data;
    rxv_p = rx_out_valid; rxr_p = rx_out_ready; rxd_p = rx_out_data;
  end

  task automatic load_upre(input logic [119:0] v);
    @(negedge clk);
    upre_load = 1'b1; upre_bytes = v;
    @(negedge clk);
    upre_load = 1'b0;
    tb_loaded = 1; tb_upre = v;
  endtask

  function automatic logic [119:0] rand_upre();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic run_tx(input int len, input bit uen, input int nb, input bit chg,
                        input string req);
    logic [8:0] exp[$];
    logic [7:0] d[$];
    int eff;
    bit use_u;
    int t;
    bit ok;
    int bad;
    eff = (len < 3) ? 3 : len;
    use_u = uen && tb_loaded;
    if (use_u) tb_loaded = 0;
    for (int i = 0; i < eff; i++) exp.push_back({1'b0, use_u ? tb_upre[8*i +: 8] : 8'h55});
    exp.push_back({1'b0, 8'hD5});
    for (int i = 0; i < nb; i++) begin
      logic [7:0] b;
      b = 8'($urandom);
      d.push_back(b);
      exp.push_back({(i == nb - 1), b});
    end
    @(negedge clk);
    cfg_len = 4'(len); cfg_tx_user = uen; txq.delete();
    fork
      begin
        for (int i = 0; i < nb; i++) begin
          tx_in_valid = 1'b1; tx_in_data = d[i]; tx_in_last = (i == nb - 1);
          @(posedge clk);
          while (!tx_in_ready) @(posedge clk);
          @(negedge clk);
        end
        tx_in_valid = 1'b0; tx_in_last = 1'b0;
      end
      begin
        if (chg) begin
          repeat (3) @(negedge clk);
          cfg_len = 4'd3; cfg_tx_user = ~uen;
        end
      end
    join
    t = 0;
    while (txq.size() < exp.size() && t < 500) begin @(negedge clk); t++; end
    chk(txq.size() == exp.size(), req, "tx byte count", txq.size(), exp.size());
    ok = 1; bad = -1;
    for (int i = 0; i < exp.size() && i < txq.size(); i++)
      if (ok && txq[i] !== exp[i]) begin ok = 0; bad = i; end
    if (bad >= 0) chk(0, req, $sformatf("tx byte %0d", bad), txq[bad], exp[bad]);
    else          chk(1, req, "tx bytes", 0, 0);
  endtask

  task automatic run_rx(input int npre, input bit keep, input int nb, input string req);
    logic [7:0] all[$];
    logic [7:0] d[$];
    logic [55:0] w;
    int t;
    int bad;
    w = '0;
    for (int i = 0; i < npre; i++) begin
      logic [7:0] b;
      b = 8'($urandom);
      if (b == 8'hD5) b = 8'h55;
      all.push_back(b);
      w = {w[47:0], b};
    end
    all.push_back(8'hD5);
    for (int i = 0; i < nb; i++) begin
      logic [7:0] b;
      b = 8'($urandom);
      d.push_back(b);
      all.push_back(b);
    end
    @(negedge clk);
    cfg_rx_keep = keep; rxq.delete(); strobes = 0; strobe_cyc = -1; first_cyc = -1;
    for (int i = 0; i < all.size(); i++) begin
      if (bp && ($urandom % 4 == 0)) begin rx_in_valid = 1'b0; @(negedge clk); end
      rx_in_valid = 1'b1; rx_in_data = all[i]; rx_in_last = (i == all.size() - 1);
      @(posedge clk);
      while (!rx_in_ready) @(posedge clk);
      @(negedge clk);
    end
    rx_in_valid = 1'b0; rx_in_last = 1'b0;
    t = 0;
    while (rxq.size() < nb && t < 500) begin @(negedge clk); t++; end
    repeat (2) @(negedge clk);
    chk(rxq.size() == nb, req, "rx byte count", rxq.size(), nb);
    bad = -1;
    for (int i = 0; i < nb && i < rxq.size(); i++)
      if (bad < 0 && rxq[i] !== {(i == nb - 1), d[i]}) bad = i;
    if (bad >= 0) chk(0, req, $sformatf("rx byte %0d", bad), rxq[bad], {(bad == nb - 1), d[bad]});
    else          chk(1, req, "rx bytes", 0, 0);
    chk(strobes == int'(keep), req, "strobe count", strobes, keep);
    if (keep) begin
      chk(strobe_word == w, req, "pre word", strobe_word, w);
      chk(strobe_cyc < first_cyc, req, "strobe before data", strobe_cyc, first_cyc);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1c0ffee));
    repeat (3) @(negedge clk);
    chk(!tx_out_valid && !tx_in_ready && !rx_out_valid && !rx_pre_valid, "R12",
        "outputs in reset", {tx_out_valid, tx_in_ready, rx_out_valid, rx_pre_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!tx_out_valid && !tx_in_ready && !rx_out_valid && !rx_pre_valid, "R12",
        "outputs after reset", {tx_out_valid, tx_in_ready, rx_out_valid, rx_pre_valid}, 0);

    run_tx(7, 0, 5, 0, "R1");
    run_tx(0, 0, 4, 0, "R2");
    run_tx(2, 0, 2, 0, "R2");
    run_tx(15, 0, 3, 0, "R2");
    run_tx(7, 1, 4, 0, "R4");
    load_upre(rand_upre());
    run_tx(9, 1, 4, 0, "R3");
    run_tx(9, 1, 4, 0, "R3");
    load_upre(rand_upre());
    run_tx(5, 0, 3, 0, "R3");
    run_tx(15, 1, 3, 0, "R3");
    run_tx(10, 0, 6, 1, "R6");
    load_upre(rand_upre());
    run_tx(12, 1, 2, 1, "R6");

    run_rx(7, 0, 5, "R7");
    run_rx(7, 0, 3, "R10");
    run_rx(7, 1, 5, "R8");
    run_rx(12, 1, 4, "R8");
    run_rx(3, 1, 4, "R9");
    run_rx(0, 1, 2, "R9");

    bp = 1;
    for (int k = 0; k < 20; k++) begin
      if ($urandom % 3 == 0) load_upre(rand_upre());
      run_tx(int'($urandom % 16), bit'($urandom % 2), 1 + int'($urandom % 12),
             bit'($urandom % 4 == 0), "R11");
    end
    for (int k = 0; k < 20; k++)
      run_rx(int'($urandom % 14), bit'($urandom % 2), 1 + int'($urandom % 12), "R11");
    bp = 0;
    repeat (4) @(negedge clk);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule